// File: doc/BRIEF.md
# Prescaled PWM Channel Generator

A single pulse-width-modulated output channel that can be instantiated once per output. Its count clock is chosen by a 3-bit select field. The choices are the system clock divided by 1, 4, 16 or 64, or rising edges seen on an external input pin. An 8-bit timer advances once per count-clock tick. When the timer is at zero, the output latch is set. When the timer equals the programmed duty value, the latch is reset. A set of 256 ticks therefore forms one period, and the output is high for as many ticks as the duty value.

Software-like configuration comes in through a narrow write port. One address holds a control byte with the run enable, the clock select and the output enable. The other address holds the 8-bit duty value. A newly written duty value waits in a holding register and takes effect only when the timer wraps to zero, so every period uses one complete duty value. Everything runs on the system clock. The external pin is synchronised and turned into a one-cycle tick.

Top module: `pwm_prescaled_chan`

## Requirements
- R1: After reset the channel is stopped with select code 000, output enable off and duty 0. `pwmOut` is low and stays low until the channel is started.
- R2: Select codes 000, 001, 010 and 011 tick the timer every 1, 4, 16 or 64 system clocks. One output period is 256 ticks, so it lasts 256, 1024, 4096 or 16384 clocks.
- R3: Any select code with its top bit set (1XX) ticks the timer once per rising edge of `extClkIn`, sampled through a two-flop synchroniser. While the pin is static, the output does not change.
- R4: With duty value D between 1 and 255, the output is high for exactly D ticks of every 256-tick period. The first tick after the channel starts finds the timer at zero and drives the output high.
- R5: Duty value 0 gives a constant low output, because a reset by the match comparator wins over a set by the zero comparator on the same tick.
- R6: A duty value written while running takes effect only when the timer wraps from 255 to 0. Every high pulse therefore lasts either the old or the new duty, never a mix. While stopped, a written duty takes effect at once.
- R7: Clearing the run enable holds the timer at zero and forces the output low one clock after the write. Restarting begins a fresh period.
- R8: While the output enable is 0, `pwmOut` stays low and the channel keeps counting. Setting the output enable again shows the running waveform.
- R9: Control byte layout (`regSel`=0): bit 0 is the run enable, bits 3..1 are the clock select with bit 3 as its top bit, bit 4 is the output enable, and bits 7..5 are ignored. `regSel`=1 writes the duty value from all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Write strobe for the register port |
| regSel | input | 1 | 0 selects the control byte, 1 selects the duty value |
| regWdata | input | 8 | Write data |
| extClkIn | input | 1 | External count clock pin (asynchronous) |
| pwmOut | output | 1 | PWM output after the output-enable gate |

## Verification
Duty values are tried at the extremes (0 and 255), at mid values, and at random values under each prescale code and under the external pin. High time is counted over whole periods. This separates a wrong prescale ratio, an off-by-one comparator and a lost reset priority. Duty rewrites in the middle of a period are checked by measuring every high pulse that follows; a pulse that matches neither the old nor the new value exposes an update that was not deferred to the wrap. Stopping, restarting, gating the output and holding the external pin static show whether the timer is really cleared, keeps counting, or is frozen.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int SEL_W = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;        // channel enabled
    logic tick;       // one-cycle count-clock pulse
    logic dutyWrite;  // duty register write this cycle
  } chanStrobes_t;
endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STEP_LOG    = 2,  // each select step multiplies the divide ratio by 2**STEP_LOG
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              extClkIn,
  output chanStrobes_t      strobes,
  output logic              outEn
);
  localparam int NUM_DIV = 4;
  localparam int PRESC_W = (NUM_DIV - 1) * STEP_LOG;

  logic             runEn;
  logic [SEL_W-1:0] selCode;
  logic             outEnQ;

  // Control byte: bit0 run, bits3..1 select, bit4 output enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      selCode <= '0;
      outEnQ  <= 1'b0;
    end else if (regWe && !regSel) begin
      runEn   <= regWdata[0];
      selCode <= regWdata[3:1];
      outEnQ  <= regWdata[4];
    end
  end

  // External pin synchroniser plus edge-detect stage
  logic [SYNC_STAGES:0] syncQ;
  logic                 extRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], extClkIn};
  end

  assign extRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // Prescaler, held at zero while stopped
  logic [PRESC_W-1:0] prescQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       prescQ <= '0;
    else if (!runEn) prescQ <= '0;
    else             prescQ <= prescQ + 1'b1;
  end

  logic [NUM_DIV-1:0] divTick;

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
    if (k == 0) begin : g_full
      assign divTick[k] = 1'b1;
    end else begin : g_part
      assign divTick[k] = &prescQ[k*STEP_LOG-1:0];
    end
  end

  logic rawTick;
  assign rawTick = selCode[SEL_W-1] ? extRise : divTick[selCode[1:0]];

  assign strobes.run       = runEn;
  assign strobes.tick      = runEn & rawTick;
  assign strobes.dutyWrite = regWe & regSel;
  assign outEn             = outEnQ;

  // R3: an external-pin tick lasts one cycle only
  assert_ext_tick_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    extRise |=> !extRise);

  // R2: the divide-by-4 tick never fires on two cycles in a row
  assert_div4_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    divTick[1] |=> !divTick[1]);
endmodule

// File: rtl/pwm_chan_datapath.sv
module pwm_chan_datapath
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobes_t     strobes,
  input  logic [CNT_W-1:0] dutyData,
  output logic             latchQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] timerQ;
  logic [CNT_W-1:0] pendDuty;
  logic [CNT_W-1:0] activeDuty;
  logic [CNT_W-1:0] nextPend;
  logic             wrapTick;
  logic             zeroHit;
  logic             matchHit;

  assign nextPend = strobes.dutyWrite ? dutyData : pendDuty;
  assign wrapTick = strobes.tick && (timerQ == CNT_MAX);
  assign zeroHit  = (timerQ == '0);
  assign matchHit = (timerQ == activeDuty);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendDuty   <= '0;
      activeDuty <= '0;
    end else begin
      pendDuty <= nextPend;
      if (!strobes.run || wrapTick) activeDuty <= nextPend;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timerQ <= '0;
    else if (!strobes.run)  timerQ <= '0;
    else if (strobes.tick)  timerQ <= timerQ + 1'b1;
  end

  // Set/reset latch; reset has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchQ <= 1'b0;
    else if (!strobes.run) latchQ <= 1'b0;
    else if (strobes.tick) begin
      if (matchHit)     latchQ <= 1'b0;
      else if (zeroHit) latchQ <= 1'b1;
    end
  end

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |=> (timerQ == '0) && !latchQ);

  assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && strobes.tick) |=> timerQ == $past(timerQ) + 1'b1);

  assert_timer_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !strobes.tick) |=> $stable(timerQ));

  assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && strobes.tick && zeroHit && activeDuty == '0) |=> !latchQ);

  assert_duty_only_at_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !wrapTick) |=> $stable(activeDuty));
endmodule

// File: rtl/pwm_prescaled_chan.sv
module pwm_prescaled_chan
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int STEP_LOG = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regSel,
  input  logic [CNT_W-1:0] regWdata,
  input  logic             extClkIn,
  output logic             pwmOut
);
  chanStrobes_t strobes;
  logic         outEn;
  logic         latchQ;

  pwm_chan_ctrl #(
    .DATA_W(CNT_W), .STEP_LOG(STEP_LOG), .SYNC_STAGES(2)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .extClkIn(extClkIn),
    .strobes(strobes), .outEn(outEn)
  );

  pwm_chan_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .dutyData(regWdata), .latchQ(latchQ)
  );

  assign pwmOut = latchQ & outEn;
endmodule

// File: tb/test_pwm_prescaled_chan.sv
module test_pwm_prescaled_chan;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWdata = '0;
  logic       extClkIn = 1'b0;
  logic       pwmOut;

  int  total = 0;
  int  bad = 0;
  bit  extRun = 1'b0;
  bit  finished = 1'b0;

  pwm_prescaled_chan i_pwm_prescaled_chan (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .extClkIn(extClkIn), .pwmOut(pwmOut)
  );

  always #(CLK_P/2) clk = ~clk;

  // external pin: toggles every 4 clocks -> one rising edge per 8 clocks
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (extRun) begin
        cnt++;
        if (cnt == 4) begin extClkIn = ~extClkIn; cnt = 0; end
      end
    end
  end

  function automatic int expHigh(int duty, int divN);
    return duty * divN;
  endfunction

  function automatic int divOf(int sel);
    if (sel >= 4) return 8;          // external: one tick per 8 clocks
    return 1 << (2 * sel);
  endfunction

  function automatic logic [7:0] ctrlByte(int sel, bit run, bit oe);
    return {3'b000, oe, sel[2:0], run};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(bit sel, logic [7:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic measure(int n, output int highs);
    highs = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
  endtask

  task automatic countToggles(int n, output int toggles);
    logic prev;
    toggles = 0;
    prev = pwmOut;
    repeat (n) begin
      @(negedge clk);
      if (pwmOut != prev) toggles++;
      prev = pwmOut;
    end
  endtask

  // every full high pulse must be old or new duty length (div1)
  task automatic pulseCheck(int oldD, int newD, int cycles);
    bit started = 0;
    int len = 0;
    logic prev = pwmOut;
    repeat (cycles) begin
      @(negedge clk);
      if (pwmOut) len++;
      if (prev && !pwmOut) begin
        if (started) check("R6 pulse length", len, (len == oldD) ? oldD : newD);
        started = 1;
      end
      if (!pwmOut) len = 0;
      prev = pwmOut;
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h;
    int t;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset output", int'(pwmOut), 0);

    // R1: stopped after reset; duty written while stopped loads at once (R6)
    writeReg(1'b1, 8'd100);
    measure(600, h);
    check("R1 stays stopped", h, 0);

    // R9 layout, R4 first tick sets output
    writeReg(1'b0, ctrlByte(0, 1, 1));
    @(negedge clk);
    check("R4 first tick high", int'(pwmOut), 1);
    measure(256 - 1, h);
    measure(256, h);
    check("R4 R2 div1 duty 100", h, expHigh(100, 1));

    // R9: upper bits ignored
    writeReg(1'b0, 8'hE0 | ctrlByte(0, 1, 1));
    measure(256, h);
    check("R9 upper bits ignored", h, expHigh(100, 1));

    // R7 stop
    writeReg(1'b0, ctrlByte(0, 0, 1));
    @(negedge clk);
    check("R7 low after stop", int'(pwmOut), 0);
    measure(300, h);
    check("R7 held low", h, 0);
    writeReg(1'b0, ctrlByte(0, 1, 1));
    @(negedge clk);
    check("R7 restart fresh period", int'(pwmOut), 1);

    // R8 output enable gating
    writeReg(1'b0, ctrlByte(0, 1, 0));
    measure(512, h);
    check("R8 gated low", h, 0);
    writeReg(1'b0, ctrlByte(0, 1, 1));
    measure(256, h);
    check("R8 ungated", h, expHigh(100, 1));

    // R5 duty 0, duty 255
    writeReg(1'b1, 8'd0);
    measure(600, h);
    measure(256, h);
    check("R5 duty zero", h, 0);
    writeReg(1'b1, 8'd255);
    measure(600, h);
    measure(256, h);
    check("R4 duty 255", h, expHigh(255, 1));

    // R2 prescale codes
    writeReg(1'b1, 8'd77);
    writeReg(1'b0, ctrlByte(1, 1, 1));
    measure(2 * 1024, h);
    measure(1024, h);
    check("R2 div4", h, expHigh(77, 4));
    writeReg(1'b1, 8'd40);
    writeReg(1'b0, ctrlByte(2, 1, 1));
    measure(2 * 4096, h);
    measure(4096, h);
    check("R2 div16", h, expHigh(40, 16));
    writeReg(1'b1, 8'd9);
    writeReg(1'b0, ctrlByte(3, 1, 1));
    measure(2 * 16384, h);
    measure(16384, h);
    check("R2 div64", h, expHigh(9, 64));

    // R3 external pin, codes 100 and 111
    extRun = 1'b1;
    writeReg(1'b1, 8'd50);
    writeReg(1'b0, ctrlByte(4, 1, 1));
    measure(2 * 2048, h);
    measure(2048, h);
    check("R3 ext code 100", h, expHigh(50, 8));
    writeReg(1'b0, ctrlByte(7, 1, 1));
    measure(2048, h);
    measure(2048, h);
    check("R3 ext code 111", h, expHigh(50, 8));
    extRun = 1'b0;
    repeat (8) @(negedge clk);
    countToggles(3000, t);
    check("R3 static pin frozen", t, 0);

    // R6 rewrite mid-period, div1, several offsets
    writeReg(1'b0, ctrlByte(0, 1, 1));
    for (int k = 0; k < 3; k++) begin
      writeReg(1'b1, 8'd200);
      measure(600, h);
      repeat (40 + 37 * k) @(negedge clk);
      writeReg(1'b1, 8'd30);
      pulseCheck(200, 30, 1024);
      measure(256, h);
      check("R6 new duty applied", h, expHigh(30, 1));
    end

    // random trials
    for (int k = 0; k < 8; k++) begin
      int sel = $urandom_range(1, 0);
      int duty = $urandom_range(255, 0);
      int per = 256 * divOf(sel);
      writeReg(1'b1, duty[7:0]);
      writeReg(1'b0, ctrlByte(sel, 1, 1));
      measure(2 * per, h);
      measure(per, h);
      check(duty == 0 ? "R5 random" : "R4 random", h, expHigh(duty, divOf(sel)));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule